// File: doc/BRIEF.md
# Bidirectional Card Data Buffer

This block is the single word buffer that sits between a host register port and the serial engine of a card data path. It is used in both directions, and two activity inputs from the data path select which one is live. In transmit mode, the host writes words into the buffer and the serializer takes them out one at a time. In receive mode, the deserializer deposits words and the host reads them back. When neither activity input is asserted, the buffer is idle. All of its status outputs then read low, and both data output buses read zero.

The host reaches the buffer through a window of `DEPTH` consecutive word addresses. Every address in that window reaches the same port: a write pushes a word (transmit) and a read pops one (receive). Each direction has its own flag set: full, empty, data-available and a threshold flag. There is also a sticky error bit, underrun for transmit and overrun for receive, which stays set until a host write to the clear input. When receive activity drops, the buffer is flushed.

Top module: `dfifo_dir_shared`

## Requirements
- R1: A host access counts only when `host_addr` lies in the aligned window of `DEPTH` words starting at `WIN_BASE` (default 0x20..0x3F). Every address in that window reaches the same push or pop port. An access outside the window has no effect.
- R2: The mode is transmit when only `tx_act` is high and receive when only `rx_act` is high; otherwise the buffer is idle. While a direction is not active, all of its flags, including its error flag, read 0 and its data bus reads 0. While idle, no word is pushed or popped.
- R3: In transmit mode, a window write pushes `host_wdata`. `dp_rdata` always shows the oldest stored word. A `dp_load` pulse removes that word, so the next word appears in the following cycle.
- R4: In receive mode, `dp_wr_en` pushes `dp_wdata`, and the word becomes visible from the cycle after the write. `host_rdata` always shows the oldest stored word, and a window read pops it.
- R5: For the active direction, full is 1 when `DEPTH` words are stored and empty is 1 when none are. Data-available is the inverse of empty.
- R6: `tx_half_empty` is 1 when at least `THRESH` (8) entries are free. `rx_half_full` is 1 when at least `THRESH` entries hold data.
- R7: A `dp_load` in transmit mode while the buffer is empty sets the sticky underrun bit, shown on `tx_underrun`.
- R8: A `dp_wr_en` in receive mode while the buffer is full drops the word and sets the sticky overrun bit, shown on `rx_overrun`.
- R9: A cycle with `clr_wr` high clears underrun when `clr_mask[0]` is 1 and overrun when `clr_mask[1]` is 1. An error event in the same cycle wins over the clear.
- R10: A push to a full buffer and a pop from an empty one leave the contents unchanged. A push and a pop in the same cycle, when both are accepted, leave the occupancy unchanged. Push acceptance depends only on the occupancy at the start of the cycle.
- R11: In the cycle after `rx_act` falls, the buffer is empty. The error bits are kept.
- R12: A synchronous active-high `rst` empties the buffer and clears both error bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tx_act | input | 1 | Transmit direction active |
| rx_act | input | 1 | Receive direction active |
| host_addr | input | ADDR_W | Host word address |
| host_wr_en | input | 1 | Host write strobe |
| host_wdata | input | DATA_W | Host write data |
| host_rd_en | input | 1 | Host read strobe (pops in receive mode) |
| host_rdata | output | DATA_W | Oldest word, receive mode |
| dp_load | input | 1 | Serializer took the presented word |
| dp_rdata | output | DATA_W | Oldest word, transmit mode |
| dp_wr_en | input | 1 | Deserializer word strobe |
| dp_wdata | input | DATA_W | Deserializer word |
| clr_wr | input | 1 | Clear register write |
| clr_mask | input | 2 | Bit 0 clears underrun, bit 1 clears overrun |
| tx_full | output | 1 | Transmit full |
| tx_empty | output | 1 | Transmit empty |
| tx_half_empty | output | 1 | At least THRESH entries free |
| tx_avail | output | 1 | Transmit data available |
| tx_underrun | output | 1 | Sticky underrun |
| rx_full | output | 1 | Receive full |
| rx_empty | output | 1 | Receive empty |
| rx_half_full | output | 1 | At least THRESH entries held |
| rx_avail | output | 1 | Receive data available |
| rx_overrun | output | 1 | Sticky overrun |

## Verification
The bench builds the block with its defaults: `DEPTH` 32, `DATA_W` 32, `THRESH` 8, an 8-bit address and the window at 0x20. With these values the 5-bit pointers wrap within a few hundred cycles, so the bench can fill the buffer past a wrap, overflow it, drain it and underrun it in both directions. The threshold edge is crossed at 24 and 25 stored words in transmit mode and at 7 and 8 in receive mode. Because the window is small, the addresses just outside it (0x1F and 0x40) can be exercised next to its first and last entries.

// File: rtl/dfifo_pkg.sv
package dfifo_pkg;

  typedef enum logic [1:0] {
    MODE_OFF = 2'd0,
    MODE_TX  = 2'd1,
    MODE_RX  = 2'd2
  } dfifo_mode_e;

  function automatic dfifo_mode_e decode_mode(input logic tx, input logic rx);
    if (tx && !rx)      return MODE_TX;
    else if (rx && !tx) return MODE_RX;
    else                return MODE_OFF;
  endfunction

endpackage

// File: rtl/dfifo_mem.sv
module dfifo_mem #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 32,
  parameter int PTR_W  = 5
) (
  input  logic              clk,
  input  logic              we,
  input  logic [PTR_W-1:0]  waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [PTR_W-1:0]  raddr,
  output logic [DATA_W-1:0] rdata
);

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  // Asynchronous read: the oldest word is visible in the same cycle as the pointer.
  assign rdata = mem[raddr];

endmodule

// File: rtl/dfifo_ctrl.sv
module dfifo_ctrl #(
  parameter int DEPTH = 32,
  parameter int PTR_W = 5,
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             flush,
  input  logic             push,
  input  logic             pop,
  output logic             push_ok,
  output logic             pop_ok,
  output logic [PTR_W-1:0] wr_ptr,
  output logic [PTR_W-1:0] rd_ptr,
  output logic [CNT_W-1:0] occ
);

  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);
  localparam logic [PTR_W-1:0] LAST_IDX = PTR_W'(DEPTH - 1);

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == LAST_IDX) ? '0 : p + 1'b1;
  endfunction

  assign push_ok = push && (occ != FULL_CNT);
  assign pop_ok  = pop  && (occ != '0);

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      occ    <= '0;
    end else begin
      if (push_ok) wr_ptr <= bump(wr_ptr);
      if (pop_ok)  rd_ptr <= bump(rd_ptr);
      case ({push_ok, pop_ok})
        2'b10:   occ <= occ + 1'b1;
        2'b01:   occ <= occ - 1'b1;
        default: occ <= occ;
      endcase
    end
  end

endmodule

// File: rtl/dfifo_status.sv
module dfifo_status
  import dfifo_pkg::*;
#(
  parameter int DEPTH  = 32,
  parameter int CNT_W  = 6,
  parameter int THRESH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  dfifo_mode_e      mode,
  input  logic [CNT_W-1:0] occ,
  input  logic             und_evt,
  input  logic             ovr_evt,
  input  logic             clr_wr,
  input  logic [1:0]       clr_mask,
  output logic             tx_full,
  output logic             tx_empty,
  output logic             tx_half_empty,
  output logic             tx_avail,
  output logic             tx_underrun,
  output logic             rx_full,
  output logic             rx_empty,
  output logic             rx_half_full,
  output logic             rx_avail,
  output logic             rx_overrun
);

  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);
  localparam logic [CNT_W-1:0] THR_CNT  = CNT_W'(THRESH);

  logic und_q, ovr_q;
  logic is_full, is_empty;
  logic tx_on, rx_on;

  always_ff @(posedge clk) begin
    if (rst) begin
      und_q <= 1'b0;
      ovr_q <= 1'b0;
    end else begin
      if (und_evt)                      und_q <= 1'b1;
      else if (clr_wr && clr_mask[0])   und_q <= 1'b0;
      if (ovr_evt)                      ovr_q <= 1'b1;
      else if (clr_wr && clr_mask[1])   ovr_q <= 1'b0;
    end
  end

  assign is_full  = (occ == FULL_CNT);
  assign is_empty = (occ == '0);
  assign tx_on    = (mode == MODE_TX);
  assign rx_on    = (mode == MODE_RX);

  assign tx_full       = tx_on && is_full;
  assign tx_empty      = tx_on && is_empty;
  assign tx_avail      = tx_on && !is_empty;
  assign tx_half_empty = tx_on && ((FULL_CNT - occ) >= THR_CNT);
  assign tx_underrun   = tx_on && und_q;

  assign rx_full       = rx_on && is_full;
  assign rx_empty      = rx_on && is_empty;
  assign rx_avail      = rx_on && !is_empty;
  assign rx_half_full  = rx_on && (occ >= THR_CNT);
  assign rx_overrun    = rx_on && ovr_q;

endmodule

// File: rtl/dfifo_dir_shared.sv
module dfifo_dir_shared
  import dfifo_pkg::*;
#(
  parameter int              DATA_W   = 32,
  parameter int              DEPTH    = 32,
  parameter int              ADDR_W   = 8,
  parameter int              THRESH   = 8,
  parameter logic [ADDR_W-1:0] WIN_BASE = 8'h20
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tx_act,
  input  logic              rx_act,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic              host_wr_en,
  input  logic [DATA_W-1:0] host_wdata,
  input  logic              host_rd_en,
  output logic [DATA_W-1:0] host_rdata,
  input  logic              dp_load,
  output logic [DATA_W-1:0] dp_rdata,
  input  logic              dp_wr_en,
  input  logic [DATA_W-1:0] dp_wdata,
  input  logic              clr_wr,
  input  logic [1:0]        clr_mask,
  output logic              tx_full,
  output logic              tx_empty,
  output logic              tx_half_empty,
  output logic              tx_avail,
  output logic              tx_underrun,
  output logic              rx_full,
  output logic              rx_empty,
  output logic              rx_half_full,
  output logic              rx_avail,
  output logic              rx_overrun
);

  localparam int               PTR_W    = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int               CNT_W    = $clog2(DEPTH + 1);
  localparam logic [ADDR_W-1:0] LOW_MASK = ADDR_W'(DEPTH - 1);

  dfifo_mode_e       mode;
  logic              rx_act_q;
  logic              flush;
  logic              win_hit;
  logic              push, pop, push_ok, pop_ok;
  logic [DATA_W-1:0] wdata, rdata;
  logic [PTR_W-1:0]  wr_ptr, rd_ptr;
  logic [CNT_W-1:0]  occ;
  logic              und_evt, ovr_evt;

  assign mode    = decode_mode(tx_act, rx_act);
  assign win_hit = (((host_addr ^ WIN_BASE) & ~LOW_MASK) == '0);

  always_ff @(posedge clk) begin
    if (rst) rx_act_q <= 1'b0;
    else     rx_act_q <= rx_act;
  end
  assign flush = rx_act_q && !rx_act;

  always_comb begin
    push  = 1'b0;
    pop   = 1'b0;
    wdata = host_wdata;
    case (mode)
      MODE_TX: begin
        push  = host_wr_en && win_hit;
        pop   = dp_load;
        wdata = host_wdata;
      end
      MODE_RX: begin
        push  = dp_wr_en;
        pop   = host_rd_en && win_hit;
        wdata = dp_wdata;
      end
      default: ;
    endcase
  end

  assign und_evt = (mode == MODE_TX) && pop  && !pop_ok;
  assign ovr_evt = (mode == MODE_RX) && push && !push_ok;

  dfifo_ctrl #(.DEPTH(DEPTH), .PTR_W(PTR_W), .CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rst(rst), .flush(flush), .push(push), .pop(pop),
    .push_ok(push_ok), .pop_ok(pop_ok),
    .wr_ptr(wr_ptr), .rd_ptr(rd_ptr), .occ(occ)
  );

  dfifo_mem #(.DATA_W(DATA_W), .DEPTH(DEPTH), .PTR_W(PTR_W)) u_mem (
    .clk(clk), .we(push_ok), .waddr(wr_ptr), .wdata(wdata),
    .raddr(rd_ptr), .rdata(rdata)
  );

  dfifo_status #(.DEPTH(DEPTH), .CNT_W(CNT_W), .THRESH(THRESH)) u_stat (
    .clk(clk), .rst(rst), .mode(mode), .occ(occ),
    .und_evt(und_evt), .ovr_evt(ovr_evt),
    .clr_wr(clr_wr), .clr_mask(clr_mask),
    .tx_full(tx_full), .tx_empty(tx_empty), .tx_half_empty(tx_half_empty),
    .tx_avail(tx_avail), .tx_underrun(tx_underrun),
    .rx_full(rx_full), .rx_empty(rx_empty), .rx_half_full(rx_half_full),
    .rx_avail(rx_avail), .rx_overrun(rx_overrun)
  );

  assign dp_rdata   = (mode == MODE_TX) ? rdata : '0;
  assign host_rdata = (mode == MODE_RX) ? rdata : '0;

endmodule

// File: rtl/dfifo_dir_shared_chk.sv
module dfifo_dir_shared_chk #(
  parameter int DEPTH = 32,
  parameter int CNT_W = 6
) (
  input logic             clk,
  input logic             rst,
  input logic             tx_act,
  input logic             rx_act,
  input logic             dp_load,
  input logic             dp_wr_en,
  input logic             clr_wr,
  input logic [1:0]       clr_mask,
  input logic             tx_full,
  input logic             tx_empty,
  input logic             tx_half_empty,
  input logic             tx_avail,
  input logic             tx_underrun,
  input logic             rx_full,
  input logic             rx_empty,
  input logic             rx_half_full,
  input logic             rx_avail,
  input logic             rx_overrun,
  input logic [CNT_W-1:0] occ
);

  p_idle_quiet_r2: assert property (@(posedge clk) disable iff (rst)
    (!tx_act && !rx_act) |-> !(tx_full || tx_empty || tx_avail || tx_half_empty ||
      tx_underrun || rx_full || rx_empty || rx_avail || rx_half_full || rx_overrun));

  p_tx_avail_inv_r5: assert property (@(posedge clk) disable iff (rst)
    (tx_act && !rx_act) |-> (tx_avail != tx_empty));

  p_rx_avail_inv_r5: assert property (@(posedge clk) disable iff (rst)
    (rx_act && !tx_act) |-> (rx_avail != rx_empty));

  p_full_no_room_r6: assert property (@(posedge clk) disable iff (rst)
    tx_full |-> !tx_half_empty);

  p_underrun_sticky_r7: assert property (@(posedge clk) disable iff (rst)
    (tx_underrun && !(clr_wr && clr_mask[0])) |=> (!tx_act || rx_act || tx_underrun));

  p_underrun_sets_r7: assert property (@(posedge clk) disable iff (rst)
    (tx_empty && dp_load) |=> (!tx_act || rx_act || tx_underrun));

  p_overrun_sets_r8: assert property (@(posedge clk) disable iff (rst)
    (rx_full && dp_wr_en) |=> (!rx_act || tx_act || rx_overrun));

  p_no_overflow_r10: assert property (@(posedge clk) disable iff (rst)
    occ <= CNT_W'(DEPTH));

  p_flush_empty_r11: assert property (@(posedge clk) disable iff (rst)
    $fell(rx_act) |=> (occ == '0));

endmodule

bind dfifo_dir_shared dfifo_dir_shared_chk #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .tx_act(tx_act), .rx_act(rx_act),
  .dp_load(dp_load), .dp_wr_en(dp_wr_en), .clr_wr(clr_wr), .clr_mask(clr_mask),
  .tx_full(tx_full), .tx_empty(tx_empty), .tx_half_empty(tx_half_empty),
  .tx_avail(tx_avail), .tx_underrun(tx_underrun),
  .rx_full(rx_full), .rx_empty(rx_empty), .rx_half_full(rx_half_full),
  .rx_avail(rx_avail), .rx_overrun(rx_overrun), .occ(occ)
);

// File: tb/dfifo_dir_shared_tb.sv
`timescale 1ns/1ps
module dfifo_dir_shared_tb;

  localparam int DW = 32, DEPTH = 32, AW = 8, THR = 8;
  localparam logic [AW-1:0] BASE = 8'h20;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst = 1'b1, tx_act = 0, rx_act = 0;
  logic [AW-1:0] host_addr = '0;
  logic host_wr_en = 0, host_rd_en = 0, dp_load = 0, dp_wr_en = 0, clr_wr = 0;
  logic [DW-1:0] host_wdata = '0, dp_wdata = '0;
  logic [1:0] clr_mask = '0;
  logic [DW-1:0] host_rdata, dp_rdata;
  logic tx_full, tx_empty, tx_half_empty, tx_avail, tx_underrun;
  logic rx_full, rx_empty, rx_half_full, rx_avail, rx_overrun;

  dfifo_dir_shared u_dut (
    .clk(clk), .rst(rst), .tx_act(tx_act), .rx_act(rx_act),
    .host_addr(host_addr), .host_wr_en(host_wr_en), .host_wdata(host_wdata),
    .host_rd_en(host_rd_en), .host_rdata(host_rdata),
    .dp_load(dp_load), .dp_rdata(dp_rdata), .dp_wr_en(dp_wr_en), .dp_wdata(dp_wdata),
    .clr_wr(clr_wr), .clr_mask(clr_mask),
    .tx_full(tx_full), .tx_empty(tx_empty), .tx_half_empty(tx_half_empty),
    .tx_avail(tx_avail), .tx_underrun(tx_underrun),
    .rx_full(rx_full), .rx_empty(rx_empty), .rx_half_full(rx_half_full),
    .rx_avail(rx_avail), .rx_overrun(rx_overrun)
  );

  // Reference model state
  logic [DW-1:0] q[$];
  bit m_und = 0, m_ovr = 0, m_rxprev = 0;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  task automatic check(input string tag, input string what,
                       input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  function automatic bit in_win(input logic [AW-1:0] a);
    return (a / DEPTH) == (BASE / DEPTH);
  endfunction

  task automatic model_step();
    bit tx, rx, push, pop, push_ok, pop_ok, u_ev, o_ev;
    logic [DW-1:0] wd;
    if (rst) begin
      q.delete(); m_und = 0; m_ovr = 0; m_rxprev = 0;
      return;
    end
    tx = tx_act && !rx_act;
    rx = rx_act && !tx_act;
    push = tx ? (host_wr_en && in_win(host_addr)) : (rx ? dp_wr_en : 0);
    pop  = tx ? dp_load : (rx ? (host_rd_en && in_win(host_addr)) : 0);
    wd   = tx ? host_wdata : dp_wdata;
    push_ok = push && (q.size() < DEPTH);
    pop_ok  = pop && (q.size() > 0);
    u_ev = tx && pop && !pop_ok;
    o_ev = rx && push && !push_ok;
    if (m_rxprev && !rx_act) q.delete();
    else begin
      if (pop_ok) void'(q.pop_front());
      if (push_ok) q.push_back(wd);
    end
    if (u_ev) m_und = 1; else if (clr_wr && clr_mask[0]) m_und = 0;
    if (o_ev) m_ovr = 1; else if (clr_wr && clr_mask[1]) m_ovr = 0;
    m_rxprev = rx_act;
  endtask

  task automatic compare();
    bit tx, rx;
    int n;
    string tt, rt;
    tx = tx_act && !rx_act;
    rx = rx_act && !tx_act;
    n = q.size();
    tt = tx ? "R5" : "R2";
    rt = rx ? "R5" : "R2";
    check(tt, "tx_full",  tx_full,  tx && n == DEPTH);
    check(tt, "tx_empty", tx_empty, tx && n == 0);
    check(tt, "tx_avail", tx_avail, tx && n != 0);
    check(tx ? "R6" : "R2", "tx_half_empty", tx_half_empty, tx && (DEPTH - n) >= THR);
    check(tx ? "R7" : "R2", "tx_underrun", tx_underrun, tx && m_und);
    check(rt, "rx_full",  rx_full,  rx && n == DEPTH);
    check(rt, "rx_empty", rx_empty, rx && n == 0);
    check(rt, "rx_avail", rx_avail, rx && n != 0);
    check(rx ? "R6" : "R2", "rx_half_full", rx_half_full, rx && n >= THR);
    check(rx ? "R8" : "R2", "rx_overrun", rx_overrun, rx && m_ovr);
    if (!tx) check("R2", "dp_rdata idle", dp_rdata, '0);
    else if (n > 0) check("R3", "dp_rdata", dp_rdata, q[0]);
    if (!rx) check("R2", "host_rdata idle", host_rdata, '0);
    else if (n > 0) check("R4", "host_rdata", host_rdata, q[0]);
  endtask

  task automatic cyc();
    @(posedge clk);
    model_step();
    @(negedge clk);
    compare();
    host_wr_en = 0; host_rd_en = 0; dp_load = 0; dp_wr_en = 0; clr_wr = 0; clr_mask = '0;
  endtask

  task automatic hwrite(input logic [AW-1:0] a, input logic [DW-1:0] d);
    host_addr = a; host_wdata = d; host_wr_en = 1; cyc();
  endtask
  task automatic hread(input logic [AW-1:0] a);
    host_addr = a; host_rd_en = 1; cyc();
  endtask
  task automatic dload();
    dp_load = 1; cyc();
  endtask
  task automatic dwrite(input logic [DW-1:0] d);
    dp_wdata = d; dp_wr_en = 1; cyc();
  endtask
  task automatic clr(input logic [1:0] m);
    clr_wr = 1; clr_mask = m; cyc();
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    cyc(); cyc();
    rst = 0;
    cyc();
    // R12: reset state, idle
    check("R12", "tx_empty after reset idle", tx_empty, 1'b0);

    // R2: idle mode ignores host writes
    hwrite(BASE, 32'hDEAD0001);
    tx_act = 1; cyc();
    check("R2", "idle write not stored", tx_empty, 1'b1);

    // R1: window decode, R3: transmit order
    hwrite(BASE, 32'hA0);
    hwrite(BASE + 8'd31, 32'hA1);
    hwrite(BASE - 8'd1, 32'hBAD0);
    hwrite(BASE + 8'd32, 32'hBAD1);
    hwrite(BASE + 8'd13, 32'hA2);
    check("R1", "tx_avail after window writes", tx_avail, 1'b1);
    check("R3", "oldest word", dp_rdata, 32'hA0);
    dload(); check("R3", "second word", dp_rdata, 32'hA1);
    dload(); check("R1", "third word skips out-of-window", dp_rdata, 32'hA2);
    dload();

    // fill past wrap to full, threshold crossing
    for (int i = 0; i < DEPTH; i++) hwrite(BASE + AW'(i % DEPTH), 32'h100 + i);
    check("R5", "tx_full", tx_full, 1'b1);
    hwrite(BASE, 32'hBAD2);
    check("R10", "push to full dropped", dp_rdata, 32'h100);
    // simultaneous push and pop while full: push refused, pop done
    host_addr = BASE; host_wdata = 32'hBAD3; host_wr_en = 1; dp_load = 1; cyc();
    check("R10", "full push+pop leaves 31", tx_full, 1'b0);
    // simultaneous with room: occupancy unchanged
    host_addr = BASE; host_wdata = 32'h1FF; host_wr_en = 1; dp_load = 1; cyc();
    check("R10", "push+pop keeps count", tx_full, 1'b0);
    for (int i = 0; i < 7; i++) dload();
    check("R6", "24 stored -> half empty", tx_half_empty, 1'b1);
    hwrite(BASE, 32'h2AA);
    check("R6", "25 stored -> not half empty", tx_half_empty, 1'b0);
    while (!tx_empty) dload();

    // R7: underrun, sticky, gated, clears
    dload();
    check("R7", "underrun set", tx_underrun, 1'b1);
    cyc(); check("R7", "underrun sticky", tx_underrun, 1'b1);
    tx_act = 0; cyc();
    check("R2", "underrun hidden idle", tx_underrun, 1'b0);
    tx_act = 1; cyc();
    check("R7", "underrun back", tx_underrun, 1'b1);
    clr(2'b10); check("R9", "wrong bit keeps underrun", tx_underrun, 1'b1);
    clr_wr = 1; clr_mask = 2'b01; dp_load = 1; cyc();
    check("R9", "set wins over clear", tx_underrun, 1'b1);
    clr(2'b01); check("R9", "underrun cleared", tx_underrun, 1'b0);

    // receive mode
    tx_act = 0; cyc();
    rx_act = 1; cyc();
    check("R4", "rx empty on entry", rx_empty, 1'b1);
    hread(BASE); check("R10", "pop from empty no effect", rx_empty, 1'b1);
    for (int i = 0; i < 7; i++) dwrite(32'h300 + i);
    check("R6", "7 held not half full", rx_half_full, 1'b0);
    dwrite(32'h307);
    check("R6", "8 held half full", rx_half_full, 1'b1);
    hread(BASE + 8'd5); check("R4", "rx pop order", host_rdata, 32'h301);
    hwrite(BASE, 32'hBAD4);
    hread(BASE + 8'd40);
    check("R1", "out-of-window read ignored", host_rdata, 32'h301);
    for (int i = 8; i < DEPTH + 1; i++) dwrite(32'h300 + i);
    check("R5", "rx_full", rx_full, 1'b1);
    dwrite(32'hBAD5);
    check("R8", "overrun set", rx_overrun, 1'b1);
    for (int i = 0; i < 5; i++) hread(BASE);
    dp_wdata = 32'h3AA; dp_wr_en = 1; host_addr = BASE; host_rd_en = 1; cyc();
    clr(2'b10); check("R9", "overrun cleared", rx_overrun, 1'b0);

    // R11: drop rx with data held
    check("R11", "data held before flush", rx_avail, 1'b1);
    rx_act = 0; cyc();
    rx_act = 1; cyc();
    check("R11", "flushed on rx drop", rx_empty, 1'b1);
    dwrite(32'h555); check("R11", "fresh word after flush", host_rdata, 32'h555);
    dwrite(32'h556);
    for (int i = 0; i < DEPTH; i++) dwrite(32'h600 + i);

    // R12: reset mid-run
    rst = 1; cyc(); rst = 0; cyc();
    check("R12", "reset empties", rx_empty, 1'b1);
    check("R12", "reset clears overrun", rx_overrun, 1'b0);
    rx_act = 0; cyc(); cyc();

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule